// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Controller

This block sits on the host side of an asynchronous 16-bit parallel flash bus and converts single-cycle requests into correctly timed read and write cycles. It runs from the system clock. Every bus timing minimum is a parameter given in clock cycles, so one edge can be adjusted without touching the others. These minimums are address access, chip-enable access, output-enable access, chip-enable setup and hold, write-enable low and high time, write cycle length, and the bus float time after output enable or chip enable rises. The device-side data bus is split into an output value, an output enable and an input value, so a pad cell can build the tri-state pin.

A request is either a plain read, a plain write, or a program/erase operation. For an operation, the controller issues two writes: a setup command, then confirm data. It then issues a status-read command and reads status repeatedly until the ready bit is set or a poll limit runs out. Finally it writes the read-array command. It reports the last status word, a failure flag decoded from the error bits, and a timeout flag.

Top module: `flashbus_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, chip enable, output enable and write enable are all high (inactive), the data output enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read drives the address and pulls chip enable and output enable low together. They stay low for max(address access, chip-enable access, output-enable access) cycles, 20 by default. The bus value on the last of those cycles is returned on `rsp_rdata`.
- R3: The controller never drives the data bus while output enable is low. It drives the bus only after output enable has been high for at least max(output-enable float, chip-enable float) cycles, 10 by default.
- R4: Chip enable is low for at least the setup count (2 by default) before write enable falls.
- R5: Write enable stays low for at least the pulse count (10 by default). Address and data do not change while the data bus is driven.
- R6: The data bus is driven from the cycle write enable falls until the hold count after it rises. Chip enable is still low, and data still driven, in the cycle write enable rises.
- R7: Write enable stays high for at least the high-time count (6 by default) between pulses. Successive write-enable falling edges are at least the write cycle count (20 by default) apart.
- R8: `req_ready` is high only while idle, and an accepted request drops it in the next cycle. Each request yields exactly one single-cycle `rsp_valid`. A read returns the sampled data; a write returns zero with both flags clear.
- R9: With `req_op` high (`req_write` is then ignored), the controller writes {8'h00,`req_cmd`} to `req_addr`, then `req_wdata` to `req_addr`, then {8'h00,STATUS_CMD} (default 8'h70). It then reads status at `req_addr` until bit 7 is 1, and finally writes {8'h00,ARRAY_CMD} (default 8'hFF). `rsp_rdata` returns the last status word.
- R10: `rsp_fail` is 1 exactly when the final status has bit 7 set and any of bits 5, 4, 3 or 1 set. Bits 0, 2 and 6 do not cause failure.
- R11: If POLL_LIMIT status reads all show bit 7 clear, polling stops after the POLL_LIMIT-th read. `rsp_timeout` is 1, `rsp_fail` is 0, and the read-array command is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_op | input | 1 | 1: program/erase operation with status polling |
| req_write | input | 1 | 1: plain write, 0: plain read (ignored for operations) |
| req_addr | input | ADDR_W | Flash word address |
| req_wdata | input | 16 | Write data, or confirm data for an operation |
| req_cmd | input | 8 | Setup command code for an operation |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read data or final status word |
| rsp_fail | output | 1 | Operation finished with an error bit set |
| rsp_timeout | output | 1 | Poll limit reached without ready |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_dq_out | output | 16 | Data to the flash |
| fl_dq_oe | output | 1 | Drive enable for the data pins |
| fl_dq_in | input | 16 | Data from the flash |

## Verification
The assertions check the edge-relative rules on every cycle. These are the chip-enable setup before a write pulse, the minimum pulse and high times, the hold of data and chip enable past the rising edge, frozen address and data during a drive, and the float gap after output enable. They also check that `rsp_valid` is a single-cycle pulse and that a timeout never reports failure. Only the bench scenarios, run against a behavioural flash model, can show the rest. That covers the order and content of the four command writes, the number of status reads, the error-bit decoding for different status values, the returned read data, and the 20-cycle write-to-write spacing across back-to-back cycles.

// File: rtl/flashbus_pkg.sv
`timescale 1ns/1ps
package flashbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_WRECOV,
        PH_RACCESS,
        PH_RTURN
    } phase_e;

    typedef enum logic [2:0] {
        OS_IDLE,
        OS_SINGLE,
        OS_SETUP,
        OS_CONFIRM,
        OS_STATCMD,
        OS_POLL,
        OS_ARRAY
    } op_state_e;

    localparam int READY_BIT = 7;

    function automatic int fb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // error bits are only meaningful once the ready bit is set
    function automatic logic fb_status_err(input logic [15:0] s);
        return s[READY_BIT] & (s[5] | s[4] | s[3] | s[1]);
    endfunction

endpackage

// File: rtl/flashbus_phase.sv
`timescale 1ns/1ps
module flashbus_phase
    import flashbus_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int CE_SETUP = 2,
    parameter int WE_LOW   = 10,
    parameter int HOLD     = 2,
    parameter int RECOV    = 6,
    parameter int RD_LEN   = 20,
    parameter int TURN     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [15:0]       cyc_wdata,
    output logic              cyc_idle,
    output logic              cyc_done,
    output logic [15:0]       cyc_rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in
);
    localparam int LMAX = fb_max(fb_max(fb_max(CE_SETUP, WE_LOW), fb_max(HOLD, RECOV)),
                                 fb_max(RD_LEN, TURN));
    localparam int CW   = $clog2(LMAX + 1);

    phase_e          ph;
    logic [CW-1:0]   cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]     wdata_q;
    logic [15:0]     rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (ph == PH_IDLE) begin
            if (cyc_valid) begin
                addr_q  <= cyc_addr;
                wdata_q <= cyc_wdata;
                if (cyc_write) begin
                    ph  <= PH_WSETUP;
                    cnt <= CW'(CE_SETUP - 1);
                end else begin
                    ph  <= PH_RACCESS;
                    cnt <= CW'(RD_LEN - 1);
                end
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            unique case (ph)
                PH_WSETUP:  begin ph <= PH_WPULSE; cnt <= CW'(WE_LOW - 1); end
                PH_WPULSE:  begin ph <= PH_WHOLD;  cnt <= CW'(HOLD - 1);   end
                PH_WHOLD:   begin ph <= PH_WRECOV; cnt <= CW'(RECOV - 1);  end
                PH_RACCESS: begin
                    rdata_q <= fl_dq_in;
                    ph      <= PH_RTURN;
                    cnt     <= CW'(TURN - 1);
                end
                default:    ph <= PH_IDLE;
            endcase
        end
    end

    assign cyc_idle  = (ph == PH_IDLE);
    assign cyc_done  = (cnt == '0) && ((ph == PH_WRECOV) || (ph == PH_RTURN));
    assign cyc_rdata = rdata_q;
    assign fl_addr   = addr_q;
    assign fl_dq_out = wdata_q;
    assign fl_ce_n   = !((ph == PH_WSETUP) || (ph == PH_WPULSE) ||
                         (ph == PH_WHOLD)  || (ph == PH_RACCESS));
    assign fl_oe_n   = (ph != PH_RACCESS);
    assign fl_we_n   = (ph != PH_WPULSE);
    assign fl_dq_oe  = (ph == PH_WPULSE) || (ph == PH_WHOLD);

endmodule

// File: rtl/flashbus_op.sv
`timescale 1ns/1ps
module flashbus_op
    import flashbus_pkg::*;
#(
    parameter int          ADDR_W     = 21,
    parameter int          POLL_LIMIT = 1000,
    parameter logic [7:0]  STATUS_CMD = 8'h70,
    parameter logic [7:0]  ARRAY_CMD  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [7:0]        req_cmd,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_fail,
    output logic              rsp_timeout,
    output logic              cyc_valid,
    output logic              cyc_write,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [15:0]       cyc_wdata,
    input  logic              cyc_idle,
    input  logic              cyc_done,
    input  logic [15:0]       cyc_rdata
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    op_state_e         st;
    logic              issued;
    logic              single_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [7:0]        cmd_q;
    logic [15:0]       status_q;
    logic              tmo_q;
    logic [PW-1:0]     polls;

    assign req_ready = (st == OS_IDLE);
    assign cyc_valid = (st != OS_IDLE) && !issued && cyc_idle;
    assign cyc_addr  = addr_q;
    assign cyc_write = !((st == OS_POLL) || ((st == OS_SINGLE) && !single_wr));

    always_comb begin
        unique case (st)
            OS_SETUP:   cyc_wdata = {8'h00, cmd_q};
            OS_STATCMD: cyc_wdata = {8'h00, STATUS_CMD};
            OS_ARRAY:   cyc_wdata = {8'h00, ARRAY_CMD};
            OS_CONFIRM,
            OS_SINGLE:  cyc_wdata = wdata_q;
            default:    cyc_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= OS_IDLE;
            issued      <= 1'b0;
            single_wr   <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            cmd_q       <= '0;
            status_q    <= '0;
            tmo_q       <= 1'b0;
            polls       <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_fail    <= 1'b0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (cyc_valid) issued <= 1'b1;
            if (st == OS_IDLE) begin
                if (req_valid) begin
                    addr_q    <= req_addr;
                    wdata_q   <= req_wdata;
                    cmd_q     <= req_cmd;
                    single_wr <= req_write;
                    polls     <= '0;
                    tmo_q     <= 1'b0;
                    st        <= req_op ? OS_SETUP : OS_SINGLE;
                end
            end else if (cyc_done) begin
                issued <= 1'b0;
                unique case (st)
                    OS_SINGLE: begin
                        rsp_valid   <= 1'b1;
                        rsp_rdata   <= single_wr ? 16'h0000 : cyc_rdata;
                        rsp_fail    <= 1'b0;
                        rsp_timeout <= 1'b0;
                        st          <= OS_IDLE;
                    end
                    OS_SETUP:   st <= OS_CONFIRM;
                    OS_CONFIRM: st <= OS_STATCMD;
                    OS_STATCMD: st <= OS_POLL;
                    OS_POLL: begin
                        status_q <= cyc_rdata;
                        polls    <= polls + 1'b1;
                        if (cyc_rdata[READY_BIT]) begin
                            st <= OS_ARRAY;
                        end else if (polls == PW'(POLL_LIMIT - 1)) begin
                            tmo_q <= 1'b1;
                            st    <= OS_ARRAY;
                        end
                    end
                    OS_ARRAY: begin
                        rsp_valid   <= 1'b1;
                        rsp_rdata   <= status_q;
                        rsp_fail    <= fb_status_err(status_q);
                        rsp_timeout <= tmo_q;
                        st          <= OS_IDLE;
                    end
                    default: st <= OS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flashbus_ctrl.sv
`timescale 1ns/1ps
module flashbus_ctrl
    import flashbus_pkg::*;
#(
    parameter int         ADDR_W     = 21,
    parameter int         P_CE_SETUP = 2,
    parameter int         P_WE_LOW   = 10,
    parameter int         P_WE_HIGH  = 6,
    parameter int         P_HOLD     = 2,
    parameter int         P_WR_CYCLE = 20,
    parameter int         P_ADDR_ACC = 20,
    parameter int         P_CE_ACC   = 20,
    parameter int         P_OE_ACC   = 9,
    parameter int         P_OE_FLOAT = 4,
    parameter int         P_CE_FLOAT = 10,
    parameter int         POLL_LIMIT = 1000,
    parameter logic [7:0] STATUS_CMD = 8'h70,
    parameter logic [7:0] ARRAY_CMD  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [7:0]        req_cmd,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_fail,
    output logic              rsp_timeout,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in
);
    localparam int RD_LEN = fb_max(fb_max(P_ADDR_ACC, P_CE_ACC), P_OE_ACC);
    localparam int TURN   = fb_max(P_OE_FLOAT, P_CE_FLOAT);
    localparam int RECOV  = fb_max(fb_max(P_WE_HIGH - P_HOLD,
                                          P_WR_CYCLE - P_CE_SETUP - P_WE_LOW - P_HOLD), 1);

    logic              cyc_valid, cyc_write, cyc_idle, cyc_done;
    logic [ADDR_W-1:0] cyc_addr;
    logic [15:0]       cyc_wdata, cyc_rdata;

    flashbus_op #(
        .ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT),
        .STATUS_CMD(STATUS_CMD), .ARRAY_CMD(ARRAY_CMD)
    ) i_op (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cmd(req_cmd),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail),
        .rsp_timeout(rsp_timeout),
        .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
        .cyc_wdata(cyc_wdata), .cyc_idle(cyc_idle), .cyc_done(cyc_done),
        .cyc_rdata(cyc_rdata)
    );

    flashbus_phase #(
        .ADDR_W(ADDR_W), .CE_SETUP(P_CE_SETUP), .WE_LOW(P_WE_LOW),
        .HOLD(P_HOLD), .RECOV(RECOV), .RD_LEN(RD_LEN), .TURN(TURN)
    ) i_phase (
        .clk(clk), .rst(rst),
        .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
        .cyc_wdata(cyc_wdata), .cyc_idle(cyc_idle), .cyc_done(cyc_done),
        .cyc_rdata(cyc_rdata),
        .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in)
    );

endmodule

// File: rtl/flashbus_ctrl_chk.sv
`timescale 1ns/1ps
module flashbus_ctrl_chk
    import flashbus_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int CE_SETUP  = 2,
    parameter int WE_LOW    = 10,
    parameter int WE_HIGH   = 6,
    parameter int OE_FLOAT  = 4,
    parameter int CE_FLOAT  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_fail,
    input logic              rsp_timeout,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n,
    input logic [15:0]       fl_dq_out,
    input logic              fl_dq_oe
);
    localparam int TURN = fb_max(OE_FLOAT, CE_FLOAT);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] ce_low_cnt, we_low_cnt, we_high_cnt, oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_low_cnt  <= '0;
            we_low_cnt  <= '0;
            we_high_cnt <= SAT;
            oe_high_cnt <= SAT;
        end else begin
            ce_low_cnt  <= fl_ce_n  ? '0 : ((ce_low_cnt  == SAT) ? SAT : ce_low_cnt  + 1'b1);
            we_low_cnt  <= fl_we_n  ? '0 : ((we_low_cnt  == SAT) ? SAT : we_low_cnt  + 1'b1);
            we_high_cnt <= !fl_we_n ? '0 : ((we_high_cnt == SAT) ? SAT : we_high_cnt + 1'b1);
            oe_high_cnt <= !fl_oe_n ? '0 : ((oe_high_cnt == SAT) ? SAT : oe_high_cnt + 1'b1);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !rsp_valid));

    // R3
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        fl_dq_oe |-> (fl_oe_n && oe_high_cnt >= 16'(TURN)));

    // R4
    ce_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> ce_low_cnt >= 16'(CE_SETUP));

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> we_low_cnt >= 16'(WE_LOW));

    // R5
    wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_dq_oe && $past(fl_dq_oe)) |-> ($stable(fl_dq_out) && $stable(fl_addr)));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (fl_dq_oe && !fl_ce_n));

    // R7
    we_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> we_high_cnt >= 16'(WE_HIGH));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    timeout_no_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_timeout) |-> !rsp_fail);

endmodule

bind flashbus_ctrl flashbus_ctrl_chk #(
    .ADDR_W(ADDR_W), .CE_SETUP(P_CE_SETUP), .WE_LOW(P_WE_LOW),
    .WE_HIGH(P_WE_HIGH), .OE_FLOAT(P_OE_FLOAT), .CE_FLOAT(P_CE_FLOAT)
) i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_timeout(rsp_timeout),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe)
);

// File: tb/test_flashbus_ctrl.sv
`timescale 1ns/1ps
module test_flashbus_ctrl;
    localparam int AW    = 21;
    localparam int LIMIT = 8;
    localparam logic [15:0] BUSY_STAT = 16'h0002;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_op = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [7:0]    req_cmd = '0;
    logic          req_ready, rsp_valid, rsp_fail, rsp_timeout;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] fl_addr;
    logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [15:0]   fl_dq_out, fl_dq_in;

    always #2.5 clk = ~clk;

    flashbus_ctrl #(.ADDR_W(AW), .POLL_LIMIT(LIMIT)) i_flashbus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cmd(req_cmd), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail), .rsp_timeout(rsp_timeout),
        .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- flash model ----------------
    logic        stat_mode = 1'b0;
    int          busy_left = 0;
    int          stat_reads = 0;
    logic [15:0] final_stat = '0;

    function automatic logic [15:0] arr_val(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign fl_dq_in = fl_oe_n ? 16'h0000 :
                      (stat_mode ? ((busy_left > 0) ? BUSY_STAT : final_stat)
                                 : arr_val(fl_addr));

    // ---------------- scoreboard ----------------
    logic [AW+15:0] exp_wr[$];
    logic [17:0]    exp_rsp[$];   // {fail, timeout, rdata}

    logic prev_we = 1'b1, prev_oe = 1'b1;
    int   ce_low = 0, we_low = 0, oe_low = 0, oe_high = 1000;
    int   cyc = 0, last_fall = -1000;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
            summary();
        end
        if (!rst) begin
            if (prev_we && !fl_we_n) begin
                chk(ce_low >= 2, "R4 ce setup", 64'(ce_low), 64'd2);
                chk(cyc - last_fall >= 20, "R7 write cycle", 64'(cyc - last_fall), 64'd20);
                chk(oe_high >= 10, "R3 turnaround", 64'(oe_high), 64'd10);
                last_fall = cyc;
            end
            if (!prev_we && fl_we_n) begin
                logic [AW+15:0] e;
                chk(we_low >= 10, "R5 pulse width", 64'(we_low), 64'd10);
                chk(fl_dq_oe && !fl_ce_n, "R6 hold", 64'({fl_dq_oe, fl_ce_n}), 64'b10);
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", 64'({fl_addr, fl_dq_out}), 64'd0);
                end else begin
                    e = exp_wr.pop_front();
                    chk({fl_addr, fl_dq_out} == e, "R9 write content",
                        64'({fl_addr, fl_dq_out}), 64'(e));
                end
                if (fl_dq_out[7:0] == 8'h70) stat_mode = 1'b1;
                if (fl_dq_out[7:0] == 8'hFF) stat_mode = 1'b0;
            end
            if (!prev_oe && fl_oe_n) begin
                chk(oe_low >= 20, "R2 access time", 64'(oe_low), 64'd20);
                if (stat_mode) begin
                    stat_reads++;
                    if (busy_left > 0) busy_left--;
                end
            end
            if (rsp_valid) begin
                logic [17:0] r;
                if (exp_rsp.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", 64'(rsp_rdata), 64'd0);
                end else begin
                    r = exp_rsp.pop_front();
                    chk(rsp_rdata == r[15:0], "R8/R9 rsp data", 64'(rsp_rdata), 64'(r[15:0]));
                    chk(rsp_fail == r[17], "R10 fail flag", 64'(rsp_fail), 64'(r[17]));
                    chk(rsp_timeout == r[16], "R11 timeout flag", 64'(rsp_timeout), 64'(r[16]));
                end
            end
        end
        ce_low  = fl_ce_n ? 0 : ce_low + 1;
        we_low  = fl_we_n ? 0 : we_low + 1;
        oe_low  = fl_oe_n ? 0 : oe_low + 1;
        oe_high = fl_oe_n ? oe_high + 1 : 0;
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    // ---------------- driver ----------------
    task automatic send(input logic op, input logic wr, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [7:0] c);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_write = wr;
        req_addr = a; req_wdata = d; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready drops", 64'(req_ready), 64'd0);
    endtask

    task automatic wait_done();
        while (exp_rsp.size() != 0) @(negedge clk);
        chk(exp_wr.size() == 0, "R9 all writes seen", 64'(exp_wr.size()), 64'd0);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        exp_rsp.push_back({2'b00, arr_val(a)});
        send(1'b0, 1'b0, a, 16'h0, 8'h0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
        exp_wr.push_back({a, d});
        exp_rsp.push_back({2'b00, 16'h0000});
        send(1'b0, 1'b1, a, d, 8'h0);
    endtask

    task automatic do_op(input logic [AW-1:0] a, input logic [7:0] c,
                         input logic [15:0] d, input int busy, input logic [15:0] fin);
        logic err;
        int   exp_reads;
        busy_left  = busy;
        final_stat = fin;
        stat_reads = 0;
        exp_wr.push_back({a, 8'h00, c});
        exp_wr.push_back({a, d});
        exp_wr.push_back({a, 16'h0070});
        exp_wr.push_back({a, 16'h00FF});
        err = fin[7] & (fin[5] | fin[4] | fin[3] | fin[1]);
        if (busy < LIMIT) begin
            exp_rsp.push_back({err, 1'b0, fin});
            exp_reads = busy + 1;
        end else begin
            exp_rsp.push_back({2'b01, BUSY_STAT});
            exp_reads = LIMIT;
        end
        send(1'b1, 1'b0, a, d, c);
        wait_done();
        chk(stat_reads == exp_reads, "R9/R11 poll count", 64'(stat_reads), 64'(exp_reads));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && req_ready && !rsp_valid,
            "R1 reset state",
            64'({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready, rsp_valid}), 64'b111010);

        // R2 reads at several addresses
        do_read(21'h000000); wait_done();
        do_read(21'h1FFFFF); wait_done();
        do_read(21'h0A5A5A); wait_done();

        // R4..R7 writes with distinct patterns, R3 read then write
        do_write(21'h000123, 16'hFFFE); wait_done();
        do_write(21'h100000, 16'h0001); wait_done();
        do_read(21'h000123);            wait_done();
        do_write(21'h0F0F0F, 16'hA55A); wait_done();

        // R9 operation that succeeds after a few busy polls
        do_op(21'h004000, 8'h40, 16'h1234, 3, 16'h0080);
        // R10 error bit 4 set
        do_op(21'h008000, 8'h20, 16'h00D0, 0, 16'h0090);
        // R10 error bits 5 and 1 set
        do_op(21'h00C000, 8'h40, 16'hBEEF, 2, 16'h00A2);
        // R10 bits 6, 2, 0 are not error bits
        do_op(21'h010000, 8'h40, 16'h0F0F, 1, 16'h00C5);
        // R11 never ready -> timeout after LIMIT polls
        do_op(21'h014000, 8'h20, 16'h00D0, 20, 16'h0080);

        // read after operation returns array data again
        do_read(21'h014000); wait_done();
        summary();
    end

endmodule